// File: doc/BRIEF.md
# Timestamped Fault Event Logger

This block records supply-rail fault events with a time of day. A free-running seconds counter is derived from the system clock through a writable ticks-per-second divisor. Software can load the divisor to trim the rate of the clock and can load the counter with an absolute time. Until software sets it, the counter shows seconds since reset. Five kinds of fault can be reported, each by its own strobe, and each strobe carries the index of the rail that raised it. A strobe enters the log only if two enables are set: the top-level enable for that fault kind, and the enable for that kind on that rail.

Accepted events wait in a small pending set and are written one per cycle, with the lowest type code first. Each stored entry holds the fault type, the rail index, a snapshot of the whole rail-state vector and the seconds value in the cycle of the write. Storage is an internal array of `LOG_DEPTH` entries. When the array is full, the block drops new events until software clears the log. A combinational read port returns any entry by index, and status outputs give the fill count and a full flag.

Top module: `fault_event_logger`

## Requirements
- R1: Reset state. `log_count` is 0, `log_full` is 0 and `tod_sec` is 0. The divisor takes the value of parameter `REF_HZ`, so `tod_sec` first reads 1 after exactly `REF_HZ` rising edges following reset release.
- R2: Divisor command (`cmd_sel`=1). The command loads the ticks-per-second divisor from `cmd_data`. `tod_sec` then advances by one every divisor cycles. A divisor of 0 or 1 advances it on every cycle.
- R3: Time command (`cmd_sel`=0). The command loads `tod_sec` from `cmd_data` and restarts the sub-second count, so the next increment comes a full divisor period later.
- R4: Event type codes are 0 for qualification timeout, 1 for input undervoltage, 2 for input overvoltage, 3 for output undervoltage and 4 for output overvoltage. Bit t of `evt_strobe` reports type t, and its rail index is `evt_rail[3t+:3]` (width RW each). An accepted strobe is written one cycle later at index `log_count`. The entry holds the type, the rail index, `rail_state` and `tod_sec` as they stand in the write cycle.
- R5: A strobe is accepted only if master-enable bit t and rail-enable bit t of its rail are both 1. The master enable is loaded by `cmd_sel`=3 from `cmd_data[4:0]` and resets to parameter `MASTER_RST`. The rail enables are loaded by `cmd_sel`=2 for rail `cmd_rail` from `cmd_data[4:0]` and reset to all ones.
- R6: Strobes accepted in the same cycle are written in consecutive cycles, lowest type code first.
- R7: A strobe of a type that is already pending, and is not being written in that cycle, is dropped. The pending entry keeps its original rail index.
- R8: When `log_count` equals `LOG_DEPTH`, `log_full` is 1. New events are then discarded and stored entries do not change.
- R9: A control command (`cmd_sel`=4) with `cmd_data[0]`=1 sets `log_count` to 0 and discards pending events and any strobe in that cycle. The same command with `cmd_data[0]`=0 has no effect.
- R10: `log_count` rises by exactly one for each entry written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_strobe | input | 5 | One fault strobe per type code |
| evt_rail | input | 5*RW | Rail index for each strobe, RW = clog2(NUM_RAILS) |
| rail_state | input | NUM_RAILS | Current state of all rails |
| cmd_valid | input | 1 | Register write strobe |
| cmd_sel | input | 3 | Register select: 0 time, 1 divisor, 2 rail enable, 3 master enable, 4 control |
| cmd_rail | input | RW | Rail addressed by a rail-enable write |
| cmd_data | input | 32 | Write data |
| rd_idx | input | clog2(LOG_DEPTH) | Entry index to read |
| rd_type | output | 3 | Type code of the entry |
| rd_rail | output | RW | Rail index of the entry |
| rd_state | output | NUM_RAILS | Rail snapshot of the entry |
| rd_time | output | 32 | Seconds timestamp of the entry |
| tod_sec | output | 32 | Current seconds counter |
| log_count | output | clog2(LOG_DEPTH+1) | Number of stored entries |
| log_full | output | 1 | Log is full |

## Verification
The log is driven with single strobes on different rails to check the entry fields. It is also driven with masks where the master enable blocks a type and masks where only the rail enable blocks it, which separates the two filter levels. Wide masks with several bits set show the order in which simultaneous events drain. A repeated strobe of a type still waiting shows whether the pending set drops the new strobe or overwrites the old one. Filling the log to its limit and then striking it again, and clearing it with bit 0 low and with bit 0 high, cover the limit and the clear. Divisor values of 10, 4 and 0 show that the seconds rate follows the divisor and does not use a fixed rate.

// File: rtl/flog_pkg.sv
package flog_pkg;
  localparam int NTYPES = 5;
  localparam int TYPE_W = 3;

  typedef enum logic [2:0] {
    CMD_SET_TIME  = 3'd0,
    CMD_SET_RATE  = 3'd1,
    CMD_RAIL_EN   = 3'd2,
    CMD_MASTER_EN = 3'd3,
    CMD_CONTROL   = 3'd4
  } cmd_e;

  // True when the sub-second count reaches the end of one second
  function automatic logic sec_wrap(input logic [31:0] frac, input logic [31:0] tps);
    return ({1'b0, frac} + 33'd1) >= {1'b0, tps};
  endfunction

  // Isolate the lowest set bit (highest priority)
  function automatic logic [NTYPES-1:0] lowest_bit(input logic [NTYPES-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  function automatic logic [TYPE_W-1:0] bit_index(input logic [NTYPES-1:0] oh);
    logic [TYPE_W-1:0] r;
    r = '0;
    for (int i = 0; i < NTYPES; i++)
      if (oh[i]) r = TYPE_W'(i);
    return r;
  endfunction
endpackage

// File: rtl/flog_timebase.sv
module flog_timebase #(
  parameter logic [31:0] REF_HZ = 32'd50_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        set_time,
  input  logic        set_rate,
  input  logic [31:0] wdata,
  output logic [31:0] tod
);
  import flog_pkg::*;

  logic [31:0] frac_q;
  logic [31:0] tps_q;
  logic        wrap;

  assign wrap = sec_wrap(frac_q, tps_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frac_q <= '0;
      tps_q  <= REF_HZ;
      tod    <= '0;
    end else begin
      if (set_rate) tps_q <= wdata;
      if (set_time) begin
        tod    <= wdata;
        frac_q <= '0;
      end else if (wrap) begin
        tod    <= tod + 32'd1;
        frac_q <= '0;
      end else begin
        frac_q <= frac_q + 32'd1;
      end
    end
  end

  // R2: without a time load the counter moves by at most one second per cycle
  assert_tod_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !set_time |=> (tod == $past(tod) || tod == $past(tod) + 32'd1));
endmodule

// File: rtl/flog_pending.sv
module flog_pending #(
  parameter int RW = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            flush,
  input  logic [flog_pkg::NTYPES-1:0]     qual,
  input  logic [flog_pkg::NTYPES*RW-1:0]  evt_rail,
  output logic                            pop_valid,
  output logic [flog_pkg::TYPE_W-1:0]     pop_type,
  output logic [RW-1:0]                   pop_rail
);
  import flog_pkg::*;

  logic [NTYPES-1:0] pend_q;
  logic [NTYPES-1:0] pop_mask;
  logic [NTYPES-1:0] accept;
  logic [RW-1:0]     rail_q [NTYPES];

  assign pop_mask  = lowest_bit(pend_q);
  assign pop_valid = |pend_q;
  assign pop_type  = bit_index(pop_mask);
  assign pop_rail  = rail_q[pop_type];
  // a type still waiting after this cycle refuses a second strobe
  assign accept    = qual & ~(pend_q & ~pop_mask);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) pend_q <= '0;
    else                 pend_q <= (pend_q & ~pop_mask) | accept;
  end

  for (genvar t = 0; t < NTYPES; t++) begin : g_rail
    always_ff @(posedge clk) begin
      if (!rst_n)         rail_q[t] <= '0;
      else if (accept[t]) rail_q[t] <= evt_rail[t*RW +: RW];
    end
  end

  // R6: with no new arrivals the pending set drains by exactly one per cycle
  assert_drain_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && qual == '0 && pop_valid) |=>
      ($countones(pend_q) == $countones($past(pend_q)) - 1));
endmodule

// File: rtl/flog_store.sv
module flog_store #(
  parameter int LOG_DEPTH = 32,
  parameter int NUM_RAILS = 8,
  parameter int RW        = 3,
  localparam int IDXW     = $clog2(LOG_DEPTH),
  localparam int CW       = $clog2(LOG_DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  logic                        wr_req,
  input  logic [flog_pkg::TYPE_W-1:0] wr_type,
  input  logic [RW-1:0]               wr_rail,
  input  logic [NUM_RAILS-1:0]        wr_state,
  input  logic [31:0]                 wr_time,
  input  logic [IDXW-1:0]             rd_idx,
  output logic [flog_pkg::TYPE_W-1:0] rd_type,
  output logic [RW-1:0]               rd_rail,
  output logic [NUM_RAILS-1:0]        rd_state,
  output logic [31:0]                 rd_time,
  output logic [CW-1:0]               count,
  output logic                        full
);
  import flog_pkg::*;

  logic [TYPE_W-1:0]    type_mem  [LOG_DEPTH];
  logic [RW-1:0]        rail_mem  [LOG_DEPTH];
  logic [NUM_RAILS-1:0] state_mem [LOG_DEPTH];
  logic [31:0]          time_mem  [LOG_DEPTH];
  logic                 wr_done;
  logic [IDXW-1:0]      wr_ptr;

  assign full    = (count == CW'(LOG_DEPTH));
  assign wr_done = wr_req && !full && !clear;
  assign wr_ptr  = count[IDXW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n || clear) count <= '0;
    else if (wr_done)    count <= count + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (wr_done) begin
      type_mem[wr_ptr]  <= wr_type;
      rail_mem[wr_ptr]  <= wr_rail;
      state_mem[wr_ptr] <= wr_state;
      time_mem[wr_ptr]  <= wr_time;
    end
  end

  assign rd_type  = type_mem[rd_idx];
  assign rd_rail  = rail_mem[rd_idx];
  assign rd_state = state_mem[rd_idx];
  assign rd_time  = time_mem[rd_idx];

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(LOG_DEPTH));
  assert_full_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clear) |=> $stable(count));
  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (count == $past(count) || count == $past(count) + CW'(1)));
endmodule

// File: rtl/fault_event_logger.sv
module fault_event_logger #(
  parameter int          NUM_RAILS  = 8,
  parameter int          LOG_DEPTH  = 32,
  parameter logic [31:0] REF_HZ     = 32'd50_000_000,
  parameter logic [4:0]  MASTER_RST = 5'b11111,
  localparam int         RW         = $clog2(NUM_RAILS),
  localparam int         IDXW       = $clog2(LOG_DEPTH),
  localparam int         CW         = $clog2(LOG_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [4:0]           evt_strobe,
  input  logic [5*RW-1:0]      evt_rail,
  input  logic [NUM_RAILS-1:0] rail_state,
  input  logic                 cmd_valid,
  input  logic [2:0]           cmd_sel,
  input  logic [RW-1:0]        cmd_rail,
  input  logic [31:0]          cmd_data,
  input  logic [IDXW-1:0]      rd_idx,
  output logic [2:0]           rd_type,
  output logic [RW-1:0]        rd_rail,
  output logic [NUM_RAILS-1:0] rd_state,
  output logic [31:0]          rd_time,
  output logic [31:0]          tod_sec,
  output logic [CW-1:0]        log_count,
  output logic                 log_full
);
  import flog_pkg::*;

  logic [NTYPES-1:0] master_en;
  logic [NTYPES-1:0] rail_en [NUM_RAILS];
  logic [NTYPES-1:0] qual;
  logic              set_time, set_rate, wr_rail_en, wr_master, clear;
  logic              pop_valid;
  logic [TYPE_W-1:0] pop_type;
  logic [RW-1:0]     pop_rail;

  assign set_time   = cmd_valid && cmd_sel == CMD_SET_TIME;
  assign set_rate   = cmd_valid && cmd_sel == CMD_SET_RATE;
  assign wr_rail_en = cmd_valid && cmd_sel == CMD_RAIL_EN;
  assign wr_master  = cmd_valid && cmd_sel == CMD_MASTER_EN;
  assign clear      = cmd_valid && cmd_sel == CMD_CONTROL && cmd_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      master_en <= MASTER_RST;
      for (int r = 0; r < NUM_RAILS; r++) rail_en[r] <= '1;
    end else begin
      if (wr_master)  master_en <= cmd_data[NTYPES-1:0];
      if (wr_rail_en) rail_en[cmd_rail] <= cmd_data[NTYPES-1:0];
    end
  end

  for (genvar t = 0; t < NTYPES; t++) begin : g_qual
    logic [RW-1:0] src;
    assign src     = evt_rail[t*RW +: RW];
    assign qual[t] = evt_strobe[t] & master_en[t] & rail_en[src][t];
  end

  flog_timebase #(.REF_HZ(REF_HZ)) u_time (
    .clk(clk), .rst_n(rst_n), .set_time(set_time), .set_rate(set_rate),
    .wdata(cmd_data), .tod(tod_sec)
  );

  flog_pending #(.RW(RW)) u_pend (
    .clk(clk), .rst_n(rst_n), .flush(clear), .qual(qual), .evt_rail(evt_rail),
    .pop_valid(pop_valid), .pop_type(pop_type), .pop_rail(pop_rail)
  );

  flog_store #(.LOG_DEPTH(LOG_DEPTH), .NUM_RAILS(NUM_RAILS), .RW(RW)) u_store (
    .clk(clk), .rst_n(rst_n), .clear(clear), .wr_req(pop_valid),
    .wr_type(pop_type), .wr_rail(pop_rail), .wr_state(rail_state), .wr_time(tod_sec),
    .rd_idx(rd_idx), .rd_type(rd_type), .rd_rail(rd_rail), .rd_state(rd_state),
    .rd_time(rd_time), .count(log_count), .full(log_full)
  );

  // R5: with every master enable off and nothing waiting, nothing can start waiting
  assert_master_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (master_en == '0 && !pop_valid) |=> !pop_valid);
endmodule

// File: tb/fault_event_logger_test.sv
module fault_event_logger_test;
  localparam int NR = 8;
  localparam int RW = 3;
  localparam int DEPTH = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    evt_strobe = '0;
  logic [5*RW-1:0] evt_rail = '0;
  logic [NR-1:0] rail_state = '0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_sel = '0;
  logic [RW-1:0] cmd_rail = '0;
  logic [31:0]   cmd_data = '0;
  logic [4:0]    rd_idx = '0;
  logic [2:0]    rd_type;
  logic [RW-1:0] rd_rail;
  logic [NR-1:0] rd_state;
  logic [31:0]   rd_time;
  logic [31:0]   tod_sec;
  logic [5:0]    log_count;
  logic          log_full;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  fault_event_logger #(.NUM_RAILS(NR), .LOG_DEPTH(DEPTH), .REF_HZ(32'd10),
                       .MASTER_RST(5'b11111)) uut (.*);

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] sel, input logic [RW-1:0] rail, input logic [31:0] data);
    cmd_valid = 1'b1; cmd_sel = sel; cmd_rail = rail; cmd_data = data;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic fire(input logic [4:0] mask, input logic [5*RW-1:0] rails);
    evt_strobe = mask; evt_rail = rails;
    @(negedge clk);
    evt_strobe = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic entry(input string req, input int idx, input logic [2:0] t,
                       input logic [RW-1:0] r, input logic [NR-1:0] s, input logic [31:0] tm);
    rd_idx = 5'(idx);
    #1;
    check({req, " type"}, 32'(rd_type), 32'(t));
    check({req, " rail"}, 32'(rd_rail), 32'(r));
    check({req, " state"}, 32'(rd_state), 32'(s));
    check({req, " time"}, rd_time, tm);
  endtask

  // table row: {strobe mask[10:6], rail[5:3], expected entries[2:0]}
  localparam logic [10:0] VEC [8] = '{
    {5'b00001, 3'd0, 3'd1}, {5'b00010, 3'd3, 3'd1}, {5'b00100, 3'd1, 3'd0},
    {5'b01000, 3'd5, 3'd0}, {5'b01000, 3'd2, 3'd1}, {5'b10000, 3'd7, 3'd1},
    {5'b11011, 3'd4, 3'd4}, {5'b11111, 3'd5, 3'd3}
  };

  // enable model held by the bench
  logic [4:0] m_master = 5'b11011;
  function automatic bit enabled(input int t, input int r);
    return m_master[t] && !(r == 5 && t == 3);
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int cnt;
    idle(3);
    rst_n = 1'b1;
    // R1 reset state and reset divisor
    check("R1 count", 32'(log_count), 0);
    check("R1 full", 32'(log_full), 0);
    check("R1 tod", tod_sec, 0);
    idle(9);
    check("R1 tod before period", tod_sec, 0);
    idle(1);
    check("R1 tod after period", tod_sec, 1);

    // R3 time load, R2 divisor
    cmd(3'd1, 0, 32'd4);
    cmd(3'd0, 0, 32'd500);
    check("R3 load", tod_sec, 500);
    idle(3);
    check("R3 restart sub-second", tod_sec, 500);
    idle(1);
    check("R2 divisor 4", tod_sec, 501);
    idle(4);
    check("R2 divisor 4 second period", tod_sec, 502);
    cmd(3'd1, 0, 32'd0);
    cnt = int'(tod_sec);
    idle(3);
    check("R2 divisor 0 every cycle", tod_sec, 32'(cnt + 3));
    cmd(3'd1, 0, 32'd100000);
    cmd(3'd0, 0, 32'd777);

    // R5 enables: master off for type 2, rail 5 off for type 3
    cmd(3'd3, 0, 32'h1B);
    cmd(3'd2, 3'd5, 32'h17);

    cnt = 0;
    for (int i = 0; i < 8; i++) begin
      logic [4:0] mk; logic [2:0] rl; int n0, got;
      mk = VEC[i][10:6]; rl = VEC[i][5:3];
      rail_state = 8'hA0 ^ 8'(i);
      n0 = cnt;
      fire(mk, {5{rl}});
      idle(6);
      got = 0;
      for (int t = 0; t < 5; t++)
        if (mk[t] && enabled(t, int'(rl))) begin
          entry("R4 R6 entry", n0 + got, 3'(t), rl, 8'hA0 ^ 8'(i), 32'd777);
          got++;
        end
      cnt = n0 + got;
      check("R5 R10 count", 32'(log_count), 32'(cnt));
      check("R5 table expectation", 32'(got), 32'(VEC[i][2:0]));
    end

    // R7 repeat strobe of a waiting type is dropped
    rail_state = 8'h3C;
    fire(5'b00011, {3'd0, 3'd0, 3'd0, 3'd6, 3'd6});
    fire(5'b00010, {3'd0, 3'd0, 3'd0, 3'd1, 3'd0});
    idle(4);
    check("R7 count", 32'(log_count), 32'(cnt + 2));
    entry("R7 kept rail", cnt + 1, 3'd1, 3'd6, 8'h3C, 32'd777);
    cnt += 2;

    // R9 control with bit 0 low has no effect
    cmd(3'd4, 0, 32'h0000_0002);
    check("R9 no clear", 32'(log_count), 32'(cnt));

    // R8 fill to full
    rail_state = 8'h55;
    while (cnt < DEPTH) begin
      fire(5'b10000, '0);
      idle(1);
      cnt++;
    end
    check("R8 count at limit", 32'(log_count), DEPTH);
    check("R8 full flag", 32'(log_full), 1);
    rail_state = 8'hFF;
    fire(5'b00001, {5{3'd2}});
    idle(3);
    check("R8 count frozen", 32'(log_count), DEPTH);
    entry("R8 last entry kept", DEPTH - 1, 3'd4, 3'd0, 8'h55, 32'd777);
    entry("R8 first entry kept", 0, 3'd0, 3'd0, 8'hA0, 32'd777);

    // R9 clear, then a fresh entry at index 0
    cmd(3'd4, 0, 32'h1);
    check("R9 count cleared", 32'(log_count), 0);
    check("R9 full cleared", 32'(log_full), 0);
    cmd(3'd0, 0, 32'd900);
    rail_state = 8'h81;
    fire(5'b01000, {5{3'd1}});
    idle(1);
    check("R4 R10 post-clear count", 32'(log_count), 1);
    entry("R4 post-clear entry", 0, 3'd3, 3'd1, 8'h81, 32'd900);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule